// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block sits between a bus master and a small synchronous memory array. It turns a single start address into a four-beat burst. On any rising clock edge where either of two start strobes is high, it captures the start address, the three chip enables and the burst-order select. It then steps a 2-bit beat counter on each edge where the advance input is high. The counter drives the two low address bits in either linear order or interleaved order. The upper address bits do not change during a burst.

Every edge also samples the write controls. A global write stores both 9-bit byte lanes. Otherwise a lane is stored only when the byte-write enable and that lane's enable are both high. With no write, the cycle is a read. Reads are flow-through: the word at the registered address appears on the output in the same cycle, after the edge. The output-valid flag takes the place of a tristate bus and drops when output enable is low, when the chip is deselected, or during a write cycle.

Top module: `burst_sram_seq`

## Requirements
- R1: On an edge where `cpu_strobe` or `ctl_strobe` is high, `mem_addr` becomes `addr_in` and the beat counter restarts at 0.
- R2: The chip is selected only when all three `chip_en` bits are 1. This selection is captured only on a strobe edge and is kept unchanged until the next strobe.
- R3: When `burst_order` was 0 at the start, beat k has low bits (start + k) mod 4.
- R4: When `burst_order` was 1 at the start, beat k has low bits start XOR k.
- R5: On an edge with no strobe, the counter advances by one (mod 4, wrapping) when `adv` is 1 and holds when `adv` is 0. `mem_addr` bits above bit 1 stay fixed.
- R6: When `wr_all` is 1 and the chip is selected, both lanes of the addressed word are written from `data_in`.
- R7: When `wr_all` is 0, lane i is written only if `wr_byte` and `lane_en[i]` are both 1. Lane 0 is `data_in[8:0]` and lane 1 is `data_in[17:9]`. Otherwise the cycle is a read and the memory is left unchanged.
- R8: In a read cycle, `data_out` equals the stored word at `mem_addr` in the same cycle after the edge.
- R9: `data_oe` is 0 and `data_out` is 0 when `out_en` is 0, when the chip is deselected, or in a write cycle.
- R10: While the chip is deselected, writes have no effect on memory.
- R11: After reset, `mem_addr` is 0 and the chip is deselected, so `data_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_strobe | input | 1 | Start strobe from the processor side |
| ctl_strobe | input | 1 | Start strobe from the controller side |
| adv | input | 1 | Steps the beat counter on non-strobe edges |
| burst_order | input | 1 | 1 selects interleaved order, 0 selects linear order; sampled on strobe |
| addr_in | input | ADDR_W | Start address |
| chip_en | input | 3 | Chip enables; all must be 1 to select |
| wr_all | input | 1 | Global write of both lanes |
| wr_byte | input | 1 | Byte-write enable |
| lane_en | input | LANES | Per-lane write enables |
| data_in | input | LANES*LANE_W | Write data |
| out_en | input | 1 | Asynchronous output enable |
| mem_addr | output | ADDR_W | Current registered word address |
| data_out | output | LANES*LANE_W | Flow-through read data, 0 when not driven |
| data_oe | output | 1 | High when `data_out` is driven |

## Verification
The assertions assume that the reset is held for at least one edge and that every input is settled at each rising edge. They also assume that `out_en` changes only between edges, because the output-drive property is checked against its current value. The bench meets these assumptions by changing all inputs two nanoseconds after a rising edge, and it holds reset over several edges before the first checked cycle. It fills the whole array through global writes before any read. This ensures that no flow-through read returns an uninitialised word to the comparison.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  // Low address bits of beat k for a given start and order (1 = interleaved)
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] k,
                                          input logic interleave);
    logic [1:0] r;
    if (interleave) r = start ^ k;
    else            r = start + k;
    return r;
  endfunction
endpackage

// File: rtl/bseq_counter.sv
module bseq_counter
  import bseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       step,
  input  logic [1:0] start_in,
  input  logic       mode_in,
  output logic [1:0] low_q,
  output logic [1:0] low_d
);
  logic [1:0] cnt_q, cnt_d, start_q, start_d;
  logic       mode_q, mode_d;

  always_comb begin
    start_d = load ? start_in : start_q;
    mode_d  = load ? mode_in  : mode_q;
    if (load)      cnt_d = 2'd0;
    else if (step) cnt_d = cnt_q + 2'd1;
    else           cnt_d = cnt_q;
  end

  assign low_q = beat_low(start_q, cnt_q, mode_q);
  assign low_d = beat_low(start_d, cnt_d, mode_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= 2'd0;
      start_q <= 2'd0;
      mode_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      start_q <= start_d;
      mode_q  <= mode_d;
    end
  end

  assert_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == 2'd0 && low_q == $past(start_in)));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> (low_q == $past(low_q)));
  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step) |=> (cnt_q == $past(cnt_q) + 2'd1));
  assert_linear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step && !mode_q) |=> (low_q == $past(low_q) + 2'd1));
  assert_interleave_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step && mode_q) |=>
      ((low_q ^ $past(low_q)) == ($past(cnt_q) ^ ($past(cnt_q) + 2'd1))));
endmodule

// File: rtl/bseq_write_gate.sv
module bseq_write_gate #(
  parameter int LANES = 2
) (
  input  logic             sel,
  input  logic             wr_all,
  input  logic             wr_byte,
  input  logic [LANES-1:0] lane_en,
  output logic [LANES-1:0] mask
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mask[i] = sel & (wr_all | (wr_byte & lane_en[i]));
  end
endmodule

// File: rtl/bseq_array.sv
module bseq_array #(
  parameter int AW    = 6,
  parameter int LANES = 2,
  parameter int LW    = 9
) (
  input  logic                  clk,
  input  logic [LANES-1:0]      we,
  input  logic [AW-1:0]         waddr,
  input  logic [LANES*LW-1:0]   wdata,
  input  logic [AW-1:0]         raddr,
  output logic [LANES*LW-1:0]   rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LW-1:0] store [DEPTH];
    always_ff @(posedge clk) begin
      if (we[i]) store[waddr] <= wdata[i*LW +: LW];
    end
    assign rdata[i*LW +: LW] = store[raddr];
  end
endmodule

// File: rtl/burst_sram_seq.sv
module burst_sram_seq #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cpu_strobe,
  input  logic                     ctl_strobe,
  input  logic                     adv,
  input  logic                     burst_order,
  input  logic [ADDR_W-1:0]        addr_in,
  input  logic [2:0]               chip_en,
  input  logic                     wr_all,
  input  logic                     wr_byte,
  input  logic [LANES-1:0]         lane_en,
  input  logic [LANES*LANE_W-1:0]  data_in,
  input  logic                     out_en,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [LANES*LANE_W-1:0]  data_out,
  output logic                     data_oe
);
  localparam int UW = ADDR_W - 2;
  localparam int DW = LANES * LANE_W;

  logic          strobe, sel_d, sel_q, wr_q;
  logic [UW-1:0] upper_d, upper_q;
  logic [1:0]    low_q, low_d;
  logic [LANES-1:0] wmask;
  logic [DW-1:0] rdata;
  logic [ADDR_W-1:0] waddr;

  assign strobe  = cpu_strobe | ctl_strobe;
  assign sel_d   = strobe ? (&chip_en) : sel_q;
  assign upper_d = strobe ? addr_in[ADDR_W-1:2] : upper_q;

  bseq_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .load(strobe), .step(adv),
    .start_in(addr_in[1:0]), .mode_in(burst_order),
    .low_q(low_q), .low_d(low_d)
  );

  bseq_write_gate #(.LANES(LANES)) u_wg (
    .sel(sel_d), .wr_all(wr_all), .wr_byte(wr_byte),
    .lane_en(lane_en), .mask(wmask)
  );

  assign waddr    = {upper_d, low_d};
  assign mem_addr = {upper_q, low_q};

  bseq_array #(.AW(ADDR_W), .LANES(LANES), .LW(LANE_W)) u_mem (
    .clk(clk), .we(wmask), .waddr(waddr), .wdata(data_in),
    .raddr(mem_addr), .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      sel_q   <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      upper_q <= upper_d;
      sel_q   <= sel_d;
      wr_q    <= |wmask;
    end
  end

  assign data_oe  = out_en & sel_q & ~wr_q;
  assign data_out = data_oe ? rdata : '0;

  assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (mem_addr == $past(addr_in)));
  assert_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> (mem_addr[ADDR_W-1:2] == $past(mem_addr[ADDR_W-1:2])));
  assert_sel_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(sel_q));
  assert_desel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !(&chip_en)) |-> (wmask == '0));
  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_en || !sel_q || wr_q) |-> (!data_oe && data_out == '0));
endmodule

// File: tb/test_burst_sram_seq.sv
module test_burst_sram_seq;
  localparam int AW = 6, LANES = 2, LW = 9, DW = LANES * LW;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic cpu_strobe = 0, ctl_strobe = 0, adv = 0, burst_order = 0;
  logic [AW-1:0] addr_in = '0;
  logic [2:0] chip_en = 3'b111;
  logic wr_all = 0, wr_byte = 0, out_en = 1;
  logic [LANES-1:0] lane_en = '0;
  logic [DW-1:0] data_in = '0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] data_out;
  logic data_oe;

  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  burst_sram_seq #(.ADDR_W(AW), .LANES(LANES), .LANE_W(LW)) i_burst_sram_seq (
    .clk(clk), .rst_n(rst_n), .cpu_strobe(cpu_strobe), .ctl_strobe(ctl_strobe),
    .adv(adv), .burst_order(burst_order), .addr_in(addr_in), .chip_en(chip_en),
    .wr_all(wr_all), .wr_byte(wr_byte), .lane_en(lane_en), .data_in(data_in),
    .out_en(out_en), .mem_addr(mem_addr), .data_out(data_out), .data_oe(data_oe)
  );

  // reference model state
  logic [DW-1:0] m_mem [DEPTH];
  logic [AW-3:0] m_up = '0;
  logic [1:0] m_start = '0, m_k = '0;
  logic m_il = 0, m_sel = 0, m_wr = 0;

  function automatic logic [1:0] ref_low(logic [1:0] s, logic [1:0] k, logic il);
    logic [1:0] r;
    if (il) r = {s[1] ^ k[1], s[0] ^ k[0]};
    else r = 2'((int'(s) + int'(k)) % 4);
    return r;
  endfunction

  function automatic logic [AW-1:0] ref_addr();
    return {m_up, ref_low(m_start, m_k, m_il)};
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one clock: model update at the edge, then checks 2 ns later
  task automatic tick(string atag);
    logic [AW-1:0] a;
    logic exp_oe;
    @(posedge clk);
    if (cpu_strobe || ctl_strobe) begin
      m_up = addr_in[AW-1:2]; m_start = addr_in[1:0]; m_k = 0;
      m_il = burst_order; m_sel = &chip_en;
    end else if (adv) m_k = m_k + 2'd1;
    a = ref_addr();
    m_wr = 0;
    if (m_sel) begin
      for (int i = 0; i < LANES; i++) begin
        if (wr_all || (wr_byte && lane_en[i])) begin
          m_mem[a][i*LW +: LW] = data_in[i*LW +: LW];
          m_wr = 1;
        end
      end
    end
    #2;
    exp_oe = out_en && m_sel && !m_wr;
    check(atag, "mem_addr", 32'(mem_addr), 32'(a));
    check("R9", "data_oe", 32'(data_oe), 32'(exp_oe));
    check(exp_oe ? "R8" : "R9", "data_out", 32'(data_out),
          exp_oe ? 32'(m_mem[a]) : 32'd0);
  endtask

  task automatic idle_in();
    cpu_strobe = 0; ctl_strobe = 0; adv = 0; wr_all = 0; wr_byte = 0;
    lane_en = '0; out_en = 1;
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    #1;
    check("R11", "reset mem_addr", 32'(mem_addr), 32'd0);
    check("R11", "reset data_oe", 32'(data_oe), 32'd0);

    // fill array with global writes (R6)
    for (int a = 0; a < DEPTH; a++) begin
      idle_in(); cpu_strobe = (a % 2 == 0); ctl_strobe = (a % 2 == 1);
      chip_en = 3'b111; addr_in = AW'(a); wr_all = 1; data_in = DW'($urandom);
      tick("R1");
    end
    // read back a few words written by global write (R6)
    for (int a = 0; a < 4; a++) begin
      idle_in(); ctl_strobe = 1; addr_in = AW'(a * 9); tick("R6");
    end

    // directed bursts in both orders from every start (R3, R4, wrap R5)
    for (int il = 0; il < 2; il++) begin
      for (int s = 0; s < 4; s++) begin
        idle_in(); cpu_strobe = 1; burst_order = il[0]; addr_in = AW'(20 + s);
        tick("R1");
        idle_in(); burst_order = ~il[0];
        for (int b = 0; b < 3; b++) begin adv = 1; tick(il ? "R4" : "R3"); end
        adv = 1; tick("R5");
        adv = 0; tick("R5");
      end
    end

    // byte lane writes (R7)
    idle_in(); cpu_strobe = 1; addr_in = 6'd10; wr_all = 1; data_in = 18'h3ffff; tick("R6");
    idle_in(); cpu_strobe = 1; addr_in = 6'd10; wr_byte = 1; lane_en = 2'b01;
    data_in = 18'h00000; tick("R7");
    idle_in(); cpu_strobe = 1; addr_in = 6'd10; tick("R7");
    check("R7", "lane0 only", 32'(data_out), 32'h3fe00);
    idle_in(); cpu_strobe = 1; addr_in = 6'd10; wr_byte = 1; lane_en = 2'b10;
    data_in = 18'h155aa; tick("R7");
    idle_in(); cpu_strobe = 1; addr_in = 6'd10; wr_byte = 0; lane_en = 2'b11;
    data_in = 18'h3ffff; tick("R7");
    check("R7", "no write w/o byte enable", 32'(data_out), 32'h15400);
    // deselected writes ignored (R10, R2)
    idle_in(); cpu_strobe = 1; chip_en = 3'b101; addr_in = 6'd10; wr_all = 1;
    data_in = 18'h0f0f0; tick("R2");
    idle_in(); chip_en = 3'b111; adv = 1; wr_all = 1; tick("R10");
    idle_in(); ctl_strobe = 1; addr_in = 6'd10; tick("R10");
    check("R10", "deselected write dropped", 32'(data_out), 32'h15400);
    // output enable low (R9)
    idle_in(); out_en = 0; tick("R5");
    check("R9", "oe low", 32'(data_oe), 32'd0);

    // constrained random
    for (int n = 0; n < 1500; n++) begin
      logic st;
      idle_in();
      st = ($urandom % 4) == 0;
      if (st) begin
        if ($urandom % 2) cpu_strobe = 1; else ctl_strobe = 1;
      end
      burst_order = 1'($urandom);
      addr_in = AW'($urandom);
      chip_en = (($urandom % 8) == 0) ? 3'($urandom) : 3'b111;
      adv = 1'($urandom);
      wr_all = ($urandom % 10) == 0;
      wr_byte = ($urandom % 3) == 0;
      lane_en = LANES'($urandom);
      data_in = DW'($urandom);
      out_en = ($urandom % 8) != 0;
      tick(st ? "R1" : (m_il ? "R4" : "R3"));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule